// File: doc/BRIEF.md
# Parallel Predictor-Corrector State Integrator

This block advances a bank of circuit state variables, such as inductor currents and submodule capacitor voltages, by one simulation step in every clock cycle in which stepping is enabled. Each lane holds one signed fixed-point state. Two update paths run side by side within the same cycle. The corrector applies the single-step gain (h/L or h/C) to a derivative that was evaluated at an earlier prediction. The predictor applies the doubled gain (2h/L or 2h/C) to the derivative at the present state and so estimates the state two steps ahead. Neither path waits on the other.

Logic outside the block evaluates the derivatives (arm voltages, capacitor currents) and presents them on ports. Each new prediction enters a two-entry delay. The older entry is the prediction that is due now, and it is exposed so that the outside logic can evaluate the corrector's derivative at it. The gains are constants taken from configuration inputs. Every sum saturates at the signed range of the state. A synchronous load writes programmable initial values into all lanes.

Top module: `pcint_integrator`

## Requirements
- R1: While rst_ni is low, state_o, pred_o and due_o of every lane read zero, and this takes effect without waiting for a clock edge.
- R2: When init_i is high at a clock edge, the lane's init_state_i value is written into state_o, pred_o and due_o of every lane. This happens even if step_i is high in the same cycle.
- R3: When init_i and step_i are both low at a clock edge, state_o, pred_o and due_o keep their values, whatever the gain and derivative inputs are doing.
- R4: Each step writes state_o := sat(state + floor(gain_c_i * d_corr_i / 2^FRAC_W)). Gains and derivatives are signed two's complement, and FRAC_W (default 12) is the number of fraction bits of the gain, so a gain of 4096 equals 1.0.
- R5: In the same step, pred_o := sat(state + floor(gain_p_i * d_pred_i / 2^FRAC_W)). Here "state" is the value held before the edge, which is the same value the corrector reads.
- R6: Each step moves the previous pred_o into due_o, so due_o always holds the prediction made two steps before the upcoming update.
- R7: sat() clamps a result above 2^(ST_W-1)-1 to that value and a result below -2^(ST_W-1) to that value. For ST_W=16 these limits are 32767 and -32768.
- R8: Lanes are independent. Each lane uses only its own slice of the packed inputs, where lane k occupies element [k].
- R9: A step's results appear on the outputs right after the clock edge that samples step_i, with no extra pipeline latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Simulation step clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| init_i | input | 1 | Synchronous load of initial states; takes priority over step_i |
| step_i | input | 1 | Advance all lanes by one step |
| init_state_i | input | NUM_ST x ST_W | Initial value for each lane |
| gain_c_i | input | NUM_ST x GAIN_W | Corrector gain (h/L or h/C) for each lane |
| gain_p_i | input | NUM_ST x GAIN_W | Predictor gain (2h/L or 2h/C) for each lane |
| d_corr_i | input | NUM_ST x D_W | Derivative evaluated at the due prediction |
| d_pred_i | input | NUM_ST x D_W | Derivative evaluated at the present state |
| state_o | output | NUM_ST x ST_W | Corrected state |
| pred_o | output | NUM_ST x ST_W | Newest two-ahead prediction |
| due_o | output | NUM_ST x ST_W | Prediction made one step earlier, now due |

## Verification
Some properties hold on every cycle, and the assertions check those: an idle cycle keeps all three outputs unchanged, a load writes the initial values into all of them, a step shifts pred_o into due_o, and a step with zero corrector derivative leaves the state where it was. The bench scenarios are needed for the arithmetic itself. They cover floor rounding of negative products, clamping at both rails, the fact that both paths read the same pre-step state, the priority of load over step, and the asynchronous reset in the middle of a run.

// File: rtl/pcint_pkg.sv
package pcint_pkg;
  typedef enum logic [1:0] {
    LANE_HOLD = 2'd0,
    LANE_STEP = 2'd1,
    LANE_LOAD = 2'd2
  } lane_op_e;
endpackage

// File: rtl/pcint_scaled_add.sv
// res = sat(base + floor(gain * deriv / 2^FRAC_W))
module pcint_scaled_add #(
  parameter int ST_W   = 16,
  parameter int GAIN_W = 16,
  parameter int D_W    = 16,
  parameter int FRAC_W = 12
) (
  input  logic signed [ST_W-1:0]   base_i,
  input  logic signed [GAIN_W-1:0] gain_i,
  input  logic signed [D_W-1:0]    deriv_i,
  output logic signed [ST_W-1:0]   res_o
);
  localparam int PROD_W = GAIN_W + D_W;
  localparam int ACC_W  = ((PROD_W > ST_W) ? PROD_W : ST_W) + 1;
  localparam int TOP_W  = ACC_W - ST_W + 1;

  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] scaled;
  logic signed [ACC_W-1:0]  acc;
  logic [TOP_W-1:0]         top_bits;
  logic                     ovf;

  assign prod     = gain_i * deriv_i;
  assign scaled   = prod >>> FRAC_W;   // arithmetic shift: floor
  assign acc      = {{(ACC_W-ST_W){base_i[ST_W-1]}}, base_i}
                  + {{(ACC_W-PROD_W){scaled[PROD_W-1]}}, scaled};
  assign top_bits = acc[ACC_W-1:ST_W-1];
  assign ovf      = !((&top_bits) || !(|top_bits));

  always_comb begin
    if (!ovf)                res_o = acc[ST_W-1:0];
    else if (acc[ACC_W-1])   res_o = {1'b1, {(ST_W-1){1'b0}}};
    else                     res_o = {1'b0, {(ST_W-1){1'b1}}};
  end
endmodule

// File: rtl/pcint_lane.sv
module pcint_lane
  import pcint_pkg::*;
#(
  parameter int ST_W   = 16,
  parameter int GAIN_W = 16,
  parameter int D_W    = 16,
  parameter int FRAC_W = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  lane_op_e                 op_i,
  input  logic signed [ST_W-1:0]   init_i,
  input  logic signed [GAIN_W-1:0] gain_c_i,
  input  logic signed [GAIN_W-1:0] gain_p_i,
  input  logic signed [D_W-1:0]    d_corr_i,
  input  logic signed [D_W-1:0]    d_pred_i,
  output logic signed [ST_W-1:0]   state_o,
  output logic signed [ST_W-1:0]   pred_o,
  output logic signed [ST_W-1:0]   due_o
);
  logic signed [ST_W-1:0] state_q, pred_q, due_q;
  logic signed [ST_W-1:0] corr_nxt, pred_nxt;

  // both paths read the same pre-step state
  pcint_scaled_add #(.ST_W(ST_W), .GAIN_W(GAIN_W), .D_W(D_W), .FRAC_W(FRAC_W)) u_corr (
    .base_i (state_q),
    .gain_i (gain_c_i),
    .deriv_i(d_corr_i),
    .res_o  (corr_nxt)
  );

  pcint_scaled_add #(.ST_W(ST_W), .GAIN_W(GAIN_W), .D_W(D_W), .FRAC_W(FRAC_W)) u_pred (
    .base_i (state_q),
    .gain_i (gain_p_i),
    .deriv_i(d_pred_i),
    .res_o  (pred_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      pred_q  <= '0;
      due_q   <= '0;
    end else begin
      unique case (op_i)
        LANE_LOAD: begin
          state_q <= init_i;
          pred_q  <= init_i;
          due_q   <= init_i;
        end
        LANE_STEP: begin
          state_q <= corr_nxt;
          pred_q  <= pred_nxt;
          due_q   <= pred_q;   // two-entry prediction delay
        end
        default: ;
      endcase
    end
  end

  assign state_o = state_q;
  assign pred_o  = pred_q;
  assign due_o   = due_q;
endmodule

// File: rtl/pcint_integrator.sv
module pcint_integrator
  import pcint_pkg::*;
#(
  parameter int NUM_ST = 4,
  parameter int ST_W   = 16,
  parameter int GAIN_W = 16,
  parameter int D_W    = 16,
  parameter int FRAC_W = 12
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              init_i,
  input  logic                              step_i,
  input  logic [NUM_ST-1:0][ST_W-1:0]       init_state_i,
  input  logic [NUM_ST-1:0][GAIN_W-1:0]     gain_c_i,
  input  logic [NUM_ST-1:0][GAIN_W-1:0]     gain_p_i,
  input  logic [NUM_ST-1:0][D_W-1:0]        d_corr_i,
  input  logic [NUM_ST-1:0][D_W-1:0]        d_pred_i,
  output logic [NUM_ST-1:0][ST_W-1:0]       state_o,
  output logic [NUM_ST-1:0][ST_W-1:0]       pred_o,
  output logic [NUM_ST-1:0][ST_W-1:0]       due_o
);
  lane_op_e op;

  always_comb begin
    if (init_i)      op = LANE_LOAD;
    else if (step_i) op = LANE_STEP;
    else             op = LANE_HOLD;
  end

  for (genvar k = 0; k < NUM_ST; k++) begin : g_lane
    pcint_lane #(.ST_W(ST_W), .GAIN_W(GAIN_W), .D_W(D_W), .FRAC_W(FRAC_W)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .op_i    (op),
      .init_i  (init_state_i[k]),
      .gain_c_i(gain_c_i[k]),
      .gain_p_i(gain_p_i[k]),
      .d_corr_i(d_corr_i[k]),
      .d_pred_i(d_pred_i[k]),
      .state_o (state_o[k]),
      .pred_o  (pred_o[k]),
      .due_o   (due_o[k])
    );
  end
endmodule

// File: rtl/pcint_integrator_chk.sv
module pcint_integrator_chk #(
  parameter int NUM_ST = 4,
  parameter int ST_W   = 16,
  parameter int D_W    = 16
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        init_i,
  input logic                        step_i,
  input logic [NUM_ST-1:0][ST_W-1:0] init_state_i,
  input logic [NUM_ST-1:0][D_W-1:0]  d_corr_i,
  input logic [NUM_ST-1:0][ST_W-1:0] state_o,
  input logic [NUM_ST-1:0][ST_W-1:0] pred_o,
  input logic [NUM_ST-1:0][ST_W-1:0] due_o
);
  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && !step_i) |=> ($stable(state_o) && $stable(pred_o) && $stable(due_o)));

  // R2
  load_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (state_o == $past(init_state_i) && pred_o == $past(init_state_i)
                && due_o == $past(init_state_i)));

  // R6
  pred_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !init_i) |=> (due_o == $past(pred_o)));

  // R4
  zero_slope_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !init_i && d_corr_i == '0) |=> (state_o == $past(state_o)));
endmodule

bind pcint_integrator pcint_integrator_chk #(
  .NUM_ST(NUM_ST), .ST_W(ST_W), .D_W(D_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .init_i      (init_i),
  .step_i      (step_i),
  .init_state_i(init_state_i),
  .d_corr_i    (d_corr_i),
  .state_o     (state_o),
  .pred_o      (pred_o),
  .due_o       (due_o)
);

// File: tb/tb_pcint_integrator.sv
module tb_pcint_integrator;
  localparam int N  = 4;
  localparam int SW = 16;
  localparam int GW = 16;
  localparam int DW = 16;
  localparam int FW = 12;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic init_i = 1'b0;
  logic step_i = 1'b0;
  logic [N-1:0][SW-1:0] init_state_i = '0;
  logic [N-1:0][GW-1:0] gain_c_i = '0;
  logic [N-1:0][GW-1:0] gain_p_i = '0;
  logic [N-1:0][DW-1:0] d_corr_i = '0;
  logic [N-1:0][DW-1:0] d_pred_i = '0;
  logic [N-1:0][SW-1:0] state_o, pred_o, due_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  longint m_s[N], m_p[N], m_d[N];

  always #2 clk_i = ~clk_i;

  pcint_integrator #(.NUM_ST(N), .ST_W(SW), .GAIN_W(GW), .D_W(DW), .FRAC_W(FW)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .init_i(init_i), .step_i(step_i),
    .init_state_i(init_state_i), .gain_c_i(gain_c_i), .gain_p_i(gain_p_i),
    .d_corr_i(d_corr_i), .d_pred_i(d_pred_i),
    .state_o(state_o), .pred_o(pred_o), .due_o(due_o)
  );

  function automatic longint ref_add(longint base, longint g, longint d);
    longint acc;
    acc = base + ((g * d) >>> FW);
    if (acc > 32767) acc = 32767;
    if (acc < -32768) acc = -32768;
    return acc;
  endfunction

  function automatic longint sx(logic [SW-1:0] v);
    return longint'($signed(v));
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    for (int k = 0; k < N; k++) begin
      chk(tag, $sformatf("state[%0d]", k), sx(state_o[k]), m_s[k]);
      chk(tag, $sformatf("pred[%0d]", k),  sx(pred_o[k]),  m_p[k]);
      chk(tag, $sformatf("due[%0d]", k),   sx(due_o[k]),   m_d[k]);
    end
  endtask

  // one clock edge with current inputs; model follows the requirements
  task automatic tick(bit ld, bit st);
    longint ns[N], np[N], nd[N];
    init_i = ld;
    step_i = st;
    for (int k = 0; k < N; k++) begin
      ns[k] = m_s[k]; np[k] = m_p[k]; nd[k] = m_d[k];
      if (ld) begin
        ns[k] = sx(init_state_i[k]); np[k] = ns[k]; nd[k] = ns[k];
      end else if (st) begin
        ns[k] = ref_add(m_s[k], longint'($signed(gain_c_i[k])), longint'($signed(d_corr_i[k])));
        np[k] = ref_add(m_s[k], longint'($signed(gain_p_i[k])), longint'($signed(d_pred_i[k])));
        nd[k] = m_p[k];
      end
    end
    @(posedge clk_i);
    #1;
    for (int k = 0; k < N; k++) begin
      m_s[k] = ns[k]; m_p[k] = np[k]; m_d[k] = nd[k];
    end
    init_i = 1'b0;
    step_i = 1'b0;
  endtask

  task automatic set_lane(int k, int gc, int gp, int dc, int dp);
    gain_c_i[k] = GW'(gc);
    gain_p_i[k] = GW'(gp);
    d_corr_i[k] = DW'(dc);
    d_pred_i[k] = DW'(dp);
  endtask

  task automatic t_reset;
    for (int k = 0; k < N; k++) begin m_s[k] = 0; m_p[k] = 0; m_d[k] = 0; end
    #1;
    check_all("R1 reset");
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
  endtask

  task automatic t_load;
    init_state_i[0] = SW'(1000);
    init_state_i[1] = SW'(-2000);
    init_state_i[2] = SW'(30000);
    init_state_i[3] = SW'(-30000);
    for (int k = 0; k < N; k++) set_lane(k, 4096, 8192, 100, 100);
    tick(1'b1, 1'b1);  // R2 load wins over step
    check_all("R2 load priority");
  endtask

  task automatic t_hold;
    for (int k = 0; k < N; k++) set_lane(k, 4096, 8192, 5000, -5000);
    tick(1'b0, 1'b0);
    check_all("R3 hold");
    tick(1'b0, 1'b0);
    check_all("R3 hold");
  endtask

  task automatic t_steps;
    // R8 distinct data per lane, R9 result right after the edge
    set_lane(0, 410, 820, 2000, 1500);
    set_lane(1, 4096, 8192, -300, 250);
    set_lane(2, 100, 200, 0, 7);
    set_lane(3, -2048, 4096, 64, -64);
    tick(1'b0, 1'b1);
    check_all("R4 R5 R6 R8 R9 step1");
    set_lane(0, 410, 820, -2000, 3000);
    set_lane(1, 1, 2, -1, -1);           // floor of tiny negative -> -1
    set_lane(2, 4096, 8192, 0, 0);
    set_lane(3, 3000, 6000, -7, 9);
    tick(1'b0, 1'b1);
    check_all("R4 R5 R6 step2");
    tick(1'b0, 1'b1);
    check_all("R4 R5 R6 step3");
  endtask

  task automatic t_sat;
    init_state_i[0] = SW'(32000);
    init_state_i[1] = SW'(-32000);
    init_state_i[2] = SW'(100);
    init_state_i[3] = SW'(-100);
    tick(1'b1, 1'b0);
    check_all("R2 reload");
    set_lane(0, 4096, 8192, 2000, 2000);
    set_lane(1, 4096, 8192, -2000, -2000);
    set_lane(2, 32767, 32767, 32767, -32768);
    set_lane(3, -32768, -32768, -32768, 32767);
    tick(1'b0, 1'b1);
    check_all("R7 clamp");
    chk("R7 top rail", "state[0]", sx(state_o[0]), 32767);
    chk("R7 bottom rail", "state[1]", sx(state_o[1]), -32768);
  endtask

  task automatic t_async_reset;
    set_lane(0, 4096, 4096, 10, 10);
    tick(1'b0, 1'b1);
    check_all("R4 pre-reset");
    @(negedge clk_i);
    rst_ni = 1'b0;
    #0.5;
    for (int k = 0; k < N; k++) begin m_s[k] = 0; m_p[k] = 0; m_d[k] = 0; end
    check_all("R1 async clear");
    @(posedge clk_i); #1;
    rst_ni = 1'b1;
  endtask

  initial begin
    t_reset();
    t_load();
    t_hold();
    t_steps();
    t_sat();
    t_async_reset();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule